// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Monitor

This block watches the registered command pins of a DDR SDRAM interface and classifies what the controller issued at each rising clock edge. For each edge it reports one command class as a one-hot vector, along with the bank that was addressed, the row or column address, and the auto-precharge flag. The result appears on registered outputs one cycle after the pins were sampled.

Alongside the decode, it keeps a model of which of the four banks are open. It flags protocol violations, each with a code and the offending bank:
- activating a bank that is already open;
- reading or writing a closed bank;
- touching a bank whose write with auto-precharge is still draining;
- issuing a mode register set, refresh or self-refresh entry while any bank is open;
- issuing anything other than a no-op within two clocks of a mode register set.

An illegal command never changes the bank model. The block is meant to sit beside a memory controller as a checker and decoder. It drives nothing onto the memory bus.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With clock enable high on both the previous and the current cycle and chip select low, the pins {RAS#,CAS#,WE#} decode as follows: 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 001 auto refresh, 000 mode register set (either kind), and 111 no-op. Chip select high is deselect. Exactly one bit of `cmd_class` is set, using bit indices 0 deselect, 1 no-op, 2 activate, 3 read, 4 write, 5 burst stop, 6 precharge, 7 auto refresh, 8 self-refresh entry, 9 clock-enable exit, 10 mode register set, 11 low-power/hold. All outputs show the command sampled at the previous rising edge.
- R2: `cmd_bank` equals {BA1,BA0}: 0 selects bank A, 1 selects bank B (BA0 high), 2 selects bank C (BA1 high) and 3 selects bank D.
- R3: For a read or write, `cmd_addr` is A[9:0] zero-extended and `cmd_ap` equals A10. For a precharge, `cmd_ap` equals A10. For every other class, `cmd_addr` is the full A[11:0] (the row for an activate) and `cmd_ap` is 0.
- R4: A legal activate opens the addressed bank. An activate to an open bank is flagged with error code 2.
- R5: A precharge with A10 high closes all four banks whatever BA holds. With A10 low it closes only the addressed bank. Outside the lockout, a precharge is never an error, even to a closed bank.
- R6: A read or write to a closed bank is flagged with code 3. A legal read with A10 high closes its bank at once. A write without auto-precharge leaves the bank open.
- R7: After a legal write with A10 high, a read or write to that bank in the next BURST_CLKS cycles (default 2) is flagged with code 5. After that window the bank reads as closed.
- R8: A mode register set, an auto refresh or a self-refresh entry while any bank is open is flagged with code 4.
- R9: A class other than deselect or no-op, sampled in the LOCK_CLKS cycles (default 2) after a legal mode register set, is flagged with code 1. This code takes priority over every other error code.
- R10: Clock enable going from high to low with the refresh encoding and chip select low is self-refresh entry (class 8). Any other high-to-low case is class 11. Low-to-high is class 9, and low on both cycles is class 11.
- R11: A burst stop is never flagged except by the lockout, and it changes no bank state.
- R12: A flagged command leaves the bank model as it was. `err_valid` is high exactly when `err_code` is nonzero. `err_bank` carries BA while an error is flagged and 0 otherwise.
- R13: During and right after reset, all banks are closed, the class is deselect, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_prev | input | 1 | Clock enable as sampled on the previous cycle |
| cke_now | input | 1 | Clock enable as sampled on this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_BITS | Bank address |
| addr | input | ADDR_W | Multiplexed address |
| cmd_class | output | 12 | One-hot command class |
| cmd_bank | output | BANK_BITS | Bank of the decoded command |
| cmd_addr | output | ADDR_W | Row, column or raw address |
| cmd_ap | output | 1 | Auto-precharge / all-bank flag |
| err_valid | output | 1 | A violation was flagged |
| err_code | output | 3 | 0 none, 1 lockout, 2 open-bank activate, 3 closed-bank access, 4 banks not idle, 5 draining bank |
| err_bank | output | BANK_BITS | Bank of the violating command |
| bank_open | output | NUM_BANKS | Open state of each bank, bit n for bank n |

## Verification
A wrong bank state shows at the ports on the very next command that touches that bank:
- a bank wrongly left open turns a later activate into code 2;
- a bank closed too early turns a later read into code 3;
- in both cases `bank_open` is visible one cycle after the faulty update.

A drain or lockout counter that is off by one moves the first or last flagged cycle by one edge. The bench therefore issues commands on consecutive edges right at the window boundaries and compares every output against an independent model on every cycle.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

  localparam int NUM_CLASSES = 12;
  localparam int ERR_W       = 3;

  typedef enum logic [3:0] {
    CL_DESEL  = 4'd0,
    CL_NOP    = 4'd1,
    CL_ACT    = 4'd2,
    CL_READ   = 4'd3,
    CL_WRITE  = 4'd4,
    CL_BSTOP  = 4'd5,
    CL_PRE    = 4'd6,
    CL_AREF   = 4'd7,
    CL_SREF   = 4'd8,
    CL_EXIT   = 4'd9,
    CL_MRS    = 4'd10,
    CL_LOWPWR = 4'd11
  } cls_e;

  typedef enum logic [ERR_W-1:0] {
    ER_NONE      = 3'd0,
    ER_LOCK      = 3'd1,
    ER_ACT_OPEN  = 3'd2,
    ER_RW_CLOSED = 3'd3,
    ER_NOT_IDLE  = 3'd4,
    ER_WAP_BUSY  = 3'd5
  } err_e;

  // Maps the sampled control pins to a command class.
  function automatic cls_e pin_class(input logic cke_p, input logic cke_c,
                                     input logic cs_n, input logic ras_n,
                                     input logic cas_n, input logic we_n);
    cls_e c;
    if (!cke_p) begin
      c = cke_c ? CL_EXIT : CL_LOWPWR;
    end else if (!cke_c) begin
      c = (!cs_n && {ras_n, cas_n, we_n} == 3'b001) ? CL_SREF : CL_LOWPWR;
    end else if (cs_n) begin
      c = CL_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CL_ACT;
        3'b101:  c = CL_READ;
        3'b100:  c = CL_WRITE;
        3'b110:  c = CL_BSTOP;
        3'b010:  c = CL_PRE;
        3'b001:  c = CL_AREF;
        3'b000:  c = CL_MRS;
        default: c = CL_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_quiet(input cls_e c);
    return (c == CL_DESEL) || (c == CL_NOP);
  endfunction

  function automatic logic wants_idle(input cls_e c);
    return (c == CL_MRS) || (c == CL_AREF) || (c == CL_SREF);
  endfunction

  function automatic logic is_column(input cls_e c);
    return (c == CL_READ) || (c == CL_WRITE);
  endfunction

endpackage

// File: rtl/ddrmon_decode.sv
module ddrmon_decode
  import ddrmon_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int BANK_BITS = 2
) (
  input  logic                 cke_prev,
  input  logic                 cke_now,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_BITS-1:0] ba,
  input  logic [ADDR_W-1:0]    addr,
  output cls_e                 cls_o,
  output logic [BANK_BITS-1:0] bank_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 ap_o
);

  localparam int PAD_W = ADDR_W - COL_W;

  always_comb begin
    cls_o  = pin_class(cke_prev, cke_now, cs_n, ras_n, cas_n, we_n);
    bank_o = ba;
    addr_o = is_column(cls_o) ? {{PAD_W{1'b0}}, addr[COL_W-1:0]} : addr;
    ap_o   = (is_column(cls_o) || cls_o == CL_PRE) ? addr[AP_BIT] : 1'b0;
  end

endmodule

// File: rtl/ddrmon_rules.sv
module ddrmon_rules
  import ddrmon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_BITS = 2
) (
  input  cls_e                 cls,
  input  logic [BANK_BITS-1:0] bank,
  input  logic                 lock_active,
  input  logic [NUM_BANKS-1:0] open_vec,
  input  logic [NUM_BANKS-1:0] busy_vec,
  output err_e                 err_o
);

  always_comb begin
    err_o = ER_NONE;
    if (lock_active && !is_quiet(cls)) begin
      err_o = ER_LOCK;
    end else if (cls == CL_ACT) begin
      if (open_vec[bank]) err_o = ER_ACT_OPEN;
    end else if (is_column(cls)) begin
      if (busy_vec[bank])       err_o = ER_WAP_BUSY;
      else if (!open_vec[bank]) err_o = ER_RW_CLOSED;
    end else if (wants_idle(cls)) begin
      if (|open_vec) err_o = ER_NOT_IDLE;
    end
  end

endmodule

// File: rtl/ddrmon_bank_track.sv
module ddrmon_bank_track #(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_BITS  = 2,
  parameter int BURST_CLKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_go,
  input  logic                 close_one,
  input  logic                 close_all,
  input  logic                 wap_go,
  input  logic [BANK_BITS-1:0] bank,
  output logic [NUM_BANKS-1:0] open_vec,
  output logic [NUM_BANKS-1:0] busy_vec
);

  localparam int CNT_W = $clog2(BURST_CLKS + 1);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             hit;
    logic [CNT_W-1:0] drain_cnt;

    assign hit         = (bank == BANK_BITS'(g));
    assign busy_vec[g] = (drain_cnt != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_vec[g] <= 1'b0;
        drain_cnt   <= '0;
      end else if (close_all || (close_one && hit)) begin
        open_vec[g] <= 1'b0;
        drain_cnt   <= '0;
      end else if (act_go && hit) begin
        open_vec[g] <= 1'b1;
      end else if (wap_go && hit) begin
        drain_cnt   <= CNT_W'(BURST_CLKS);
      end else if (drain_cnt == CNT_W'(1)) begin
        open_vec[g] <= 1'b0;
        drain_cnt   <= '0;
      end else if (drain_cnt != '0) begin
        drain_cnt   <= drain_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddrmon_mrd_lock.sv
module ddrmon_mrd_lock #(
  parameter int LOCK_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mrs_go,
  output logic lock_active
);

  localparam int CW = $clog2(LOCK_CLKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (mrs_go)      cnt <= CW'(LOCK_CLKS);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign lock_active = (cnt != '0);

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddrmon_pkg::*;
#(
  parameter int BANK_BITS  = 2,
  parameter int ADDR_W     = 12,
  parameter int COL_W      = 10,
  parameter int AP_BIT     = 10,
  parameter int BURST_CLKS = 2,
  parameter int LOCK_CLKS  = 2,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke_prev,
  input  logic                   cke_now,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BANK_BITS-1:0]   ba,
  input  logic [ADDR_W-1:0]      addr,
  output logic [NUM_CLASSES-1:0] cmd_class,
  output logic [BANK_BITS-1:0]   cmd_bank,
  output logic [ADDR_W-1:0]      cmd_addr,
  output logic                   cmd_ap,
  output logic                   err_valid,
  output logic [ERR_W-1:0]       err_code,
  output logic [BANK_BITS-1:0]   err_bank,
  output logic [NUM_BANKS-1:0]   bank_open
);

  cls_e                 dec_cls;
  logic [BANK_BITS-1:0] dec_bank;
  logic [ADDR_W-1:0]    dec_addr;
  logic                 dec_ap;
  err_e                 rule_err;
  logic                 lock_active;
  logic [NUM_BANKS-1:0] busy_vec;
  logic                 accept;
  logic                 act_go, close_one, close_all, wap_go, mrs_go;

  ddrmon_decode #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .BANK_BITS(BANK_BITS)
  ) u_decode (
    .cke_prev(cke_prev), .cke_now(cke_now), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cls_o(dec_cls), .bank_o(dec_bank), .addr_o(dec_addr), .ap_o(dec_ap)
  );

  ddrmon_rules #(
    .NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS)
  ) u_rules (
    .cls(dec_cls), .bank(dec_bank), .lock_active(lock_active),
    .open_vec(bank_open), .busy_vec(busy_vec), .err_o(rule_err)
  );

  // Events that move the bank model; only accepted commands count.
  assign accept    = (rule_err == ER_NONE);
  assign act_go    = accept && (dec_cls == CL_ACT);
  assign close_all = accept && (dec_cls == CL_PRE) && dec_ap;
  assign close_one = accept && (((dec_cls == CL_PRE) && !dec_ap) ||
                                ((dec_cls == CL_READ) && dec_ap));
  assign wap_go    = accept && (dec_cls == CL_WRITE) && dec_ap;
  assign mrs_go    = accept && (dec_cls == CL_MRS);

  ddrmon_bank_track #(
    .NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS), .BURST_CLKS(BURST_CLKS)
  ) u_banks (
    .clk(clk), .rst_n(rst_n), .act_go(act_go), .close_one(close_one),
    .close_all(close_all), .wap_go(wap_go), .bank(dec_bank),
    .open_vec(bank_open), .busy_vec(busy_vec)
  );

  ddrmon_mrd_lock #(
    .LOCK_CLKS(LOCK_CLKS)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .mrs_go(mrs_go), .lock_active(lock_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_class <= NUM_CLASSES'(1) << CL_DESEL;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cmd_ap    <= 1'b0;
      err_valid <= 1'b0;
      err_code  <= ER_NONE;
      err_bank  <= '0;
    end else begin
      cmd_class <= NUM_CLASSES'(1) << dec_cls;
      cmd_bank  <= dec_bank;
      cmd_addr  <= dec_addr;
      cmd_ap    <= dec_ap;
      err_valid <= !accept;
      err_code  <= rule_err;
      err_bank  <= accept ? '0 : dec_bank;
    end
  end

endmodule

// File: rtl/ddrmon_checker.sv
module ddrmon_checker
  import ddrmon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_BITS = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CLASSES-1:0] cmd_class,
  input logic [BANK_BITS-1:0]   cmd_bank,
  input logic                   cmd_ap,
  input logic                   err_valid,
  input logic [ERR_W-1:0]       err_code,
  input logic [NUM_BANKS-1:0]   bank_open,
  input logic                   lock_active
);

  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd_class) == 1); // R1

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_class[CL_ACT] && !err_valid) |-> bank_open[cmd_bank]); // R4

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_class[CL_PRE] && cmd_ap && !err_valid) |-> (bank_open == '0)); // R5

  AST_CLOSED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == ER_RW_CLOSED) |-> !bank_open[cmd_bank]); // R6

  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_class[CL_MRS] || cmd_class[CL_AREF] || cmd_class[CL_SREF]) && !err_valid)
      |-> (bank_open == '0)); // R8

  AST_LOCK_AFTER_MRS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_class[CL_MRS] && !err_valid)
      |=> (cmd_class[CL_DESEL] || cmd_class[CL_NOP] || err_code == ER_LOCK)); // R9

  AST_LOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == ER_LOCK) |-> $past(lock_active)); // R9

  AST_BSTOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_class[CL_BSTOP] |-> (err_code == ER_NONE || err_code == ER_LOCK)); // R11

endmodule

bind ddr_cmd_monitor ddrmon_checker #(
  .NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS)
) u_ddrmon_checker (
  .clk(clk), .rst_n(rst_n), .cmd_class(cmd_class), .cmd_bank(cmd_bank),
  .cmd_ap(cmd_ap), .err_valid(err_valid), .err_code(err_code),
  .bank_open(bank_open), .lock_active(lock_active)
);

// File: tb/test_ddr_cmd_monitor.sv
module test_ddr_cmd_monitor;

  localparam int BURST = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_prev = 1'b1, cke_now = 1'b1;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [11:0] cmd_class;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr;
  logic        cmd_ap;
  logic        err_valid;
  logic [2:0]  err_code;
  logic [1:0]  err_bank;
  logic [3:0]  bank_open;

  int checks = 0;
  int failures = 0;

  logic [3:0] m_open = '0;
  int         m_drain [4] = '{0, 0, 0, 0};
  int         m_lock = 0;

  always #2 clk = ~clk;

  ddr_cmd_monitor i_ddr_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke_now(cke_now),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .addr(addr), .cmd_class(cmd_class), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_ap(cmd_ap), .err_valid(err_valid),
    .err_code(err_code), .err_bank(err_bank), .bank_open(bank_open)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic cp, input logic cn, input logic cs,
                       input logic r, input logic c, input logic w,
                       input logic [1:0] b, input logic [11:0] a);
    int ecls, eerr, nlock;
    int ndrain [4];
    logic [11:0] eaddr;
    logic eap, legal;
    logic [3:0] nopen;
    string ctag, etag, otag;
    @(negedge clk);
    cke_prev = cp; cke_now = cn; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
    ba = b; addr = a;
    if (cp && cn) begin
      if (cs) ecls = 0;
      else if ({r, c, w} == 3'b011) ecls = 2;
      else if ({r, c, w} == 3'b101) ecls = 3;
      else if ({r, c, w} == 3'b100) ecls = 4;
      else if ({r, c, w} == 3'b110) ecls = 5;
      else if ({r, c, w} == 3'b010) ecls = 6;
      else if ({r, c, w} == 3'b001) ecls = 7;
      else if ({r, c, w} == 3'b000) ecls = 10;
      else ecls = 1;
    end else if (cp) begin
      ecls = (!cs && !r && !c && w) ? 8 : 11;
    end else begin
      ecls = cn ? 9 : 11;
    end
    eaddr = (ecls == 3 || ecls == 4) ? {2'b00, a[9:0]} : a;
    eap   = (ecls == 3 || ecls == 4 || ecls == 6) ? a[10] : 1'b0;
    if (m_lock > 0 && ecls > 1) eerr = 1;
    else if (ecls == 2 && m_open[b]) eerr = 2;
    else if ((ecls == 3 || ecls == 4) && m_drain[b] > 0) eerr = 5;
    else if ((ecls == 3 || ecls == 4) && !m_open[b]) eerr = 3;
    else if ((ecls == 10 || ecls == 7 || ecls == 8) && m_open != 0) eerr = 4;
    else eerr = 0;
    legal = (eerr == 0);
    nopen = m_open;
    for (int k = 0; k < 4; k++) begin
      ndrain[k] = m_drain[k];
      if (legal && ((ecls == 6 && a[10]) || (ecls == 6 && !a[10] && b == k[1:0]) ||
                    (ecls == 3 && a[10] && b == k[1:0]))) begin
        nopen[k] = 1'b0; ndrain[k] = 0;
      end else if (legal && ecls == 2 && b == k[1:0]) begin
        nopen[k] = 1'b1;
      end else if (legal && ecls == 4 && a[10] && b == k[1:0]) begin
        ndrain[k] = BURST;
      end else if (m_drain[k] == 1) begin
        nopen[k] = 1'b0; ndrain[k] = 0;
      end else if (m_drain[k] > 1) begin
        ndrain[k] = m_drain[k] - 1;
      end
    end
    nlock = (legal && ecls == 10) ? 2 : (m_lock > 0 ? m_lock - 1 : 0);
    ctag = (ecls == 8 || ecls == 9 || ecls == 11) ? "R10 class" : "R1 class";
    case (eerr)
      1: etag = "R9 error";
      2: etag = "R4 error";
      3: etag = "R6 error";
      4: etag = "R8 error";
      5: etag = "R7 error";
      default: etag = (ecls == 5) ? "R11 error" : "R12 error";
    endcase
    otag = (ecls == 6) ? "R5 banks" : (eerr == 5 ? "R7 banks" : "R12 banks");
    @(posedge clk);
    #1;
    chk(ctag, 32'(cmd_class), 32'(12'd1 << ecls));
    chk("R2 bank", 32'(cmd_bank), 32'(b));
    chk("R3 addr", 32'(cmd_addr), 32'(eaddr));
    chk("R3 ap", 32'(cmd_ap), 32'(eap));
    chk(etag, 32'(err_code), 32'(eerr));
    chk("R12 err_valid", 32'(err_valid), 32'(eerr != 0));
    chk("R12 err_bank", 32'(err_bank), eerr != 0 ? 32'(b) : 32'd0);
    chk(otag, 32'(bank_open), 32'(nopen));
    m_open = nopen;
    for (int k = 0; k < 4; k++) m_drain[k] = ndrain[k];
    m_lock = nlock;
  endtask

  task automatic cmd(input logic r, input logic c, input logic w,
                     input logic [1:0] b, input logic [11:0] a);
    issue(1'b1, 1'b1, 1'b0, r, c, w, b, a);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL R13 watchdog got=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R13 reset class", 32'(cmd_class), 32'd1);
    chk("R13 reset banks", 32'(bank_open), 32'd0);
    chk("R13 reset error", 32'(err_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // open / access / reopen
    cmd(0, 1, 1, 2'd0, 12'h5A5);         // ACT A
    cmd(0, 1, 1, 2'd3, 12'hFFF);         // ACT D
    cmd(1, 0, 1, 2'd0, 12'hBFF);         // READ A col 3FF, no AP
    cmd(0, 1, 1, 2'd0, 12'h001);         // ACT A again: R4
    cmd(1, 0, 0, 2'd1, 12'h010);         // WRITE closed B: R6
    cmd(1, 0, 0, 2'd2, 12'h010);         // WRITE closed C
    // write with AP on D and the drain window
    cmd(1, 0, 0, 2'd3, 12'h412);         // WRITE D AP
    cmd(1, 0, 1, 2'd3, 12'h000);         // busy R7
    cmd(1, 0, 0, 2'd3, 12'h000);         // busy R7
    cmd(1, 0, 1, 2'd3, 12'h000);         // now closed R6
    cmd(1, 1, 0, 2'd1, 12'h000);         // BSTOP R11
    cmd(1, 0, 0, 2'd0, 12'h020);         // WRITE A no AP stays open
    cmd(0, 1, 0, 2'd0, 12'h000);         // PRE A only
    cmd(0, 1, 0, 2'd0, 12'h000);         // PRE closed bank, legal
    cmd(0, 1, 1, 2'd1, 12'h100);         // ACT B
    cmd(0, 1, 1, 2'd2, 12'h200);         // ACT C
    cmd(1, 0, 1, 2'd2, 12'h405);         // READ C with AP closes C
    cmd(0, 0, 1, 2'd0, 12'h000);         // AREF with B open: R8
    cmd(0, 0, 0, 2'd0, 12'h000);         // MRS with B open: R8
    cmd(0, 1, 0, 2'd2, 12'h400);         // PRE all, BA ignored R5
    // lockout windows
    cmd(0, 0, 0, 2'd1, 12'h033);         // MRS legal
    cmd(0, 1, 1, 2'd1, 12'h000);         // locked R9
    cmd(1, 1, 1, 2'd0, 12'h000);         // NOP
    cmd(0, 1, 1, 2'd1, 12'h000);         // free
    cmd(0, 1, 0, 2'd1, 12'h400);         // PRE all
    cmd(0, 0, 0, 2'd0, 12'h000);         // MRS
    cmd(1, 1, 1, 2'd0, 12'h000);         // NOP
    cmd(1, 1, 0, 2'd2, 12'h000);         // BSTOP locked at second slot
    issue(1, 1, 1, 0, 0, 0, 2'd0, 12'h000); // deselect
    // refresh and clock enable
    cmd(0, 0, 1, 2'd0, 12'h000);         // AREF idle
    issue(1, 0, 0, 0, 0, 1, 2'd0, 12'h000); // SREF entry R10
    issue(0, 0, 1, 1, 1, 1, 2'd0, 12'h000); // hold
    issue(0, 1, 1, 1, 1, 1, 2'd0, 12'h000); // exit
    cmd(0, 1, 1, 2'd3, 12'h007);         // ACT D
    issue(1, 0, 0, 0, 0, 1, 2'd0, 12'h000); // SREF with D open R8
    issue(1, 0, 0, 0, 1, 1, 2'd0, 12'h000); // power-down entry
    // near-exhaustive sweep over pins, bank and A10
    for (int i = 0; i < 512; i++) begin
      int k;
      logic [8:0] v;
      k = (i * 37 + 11) % 512;
      v = k[8:0];
      issue(v[5] | v[4], v[4] | ~v[5], v[3] & v[2], v[0], v[1], v[2], v[7:6],
            {1'b0, v[8], 10'(i * 91)});
    end
    for (int i = 0; i < 4; i++) cmd(1, 1, 1, 2'(i), 12'h000);
    cmd(0, 1, 0, 2'd0, 12'h400);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule